// File: doc/BRIEF.md
# Two-key watchdog with clock monitor

This block is a computer-operating-properly watchdog for a small microcontroller. It runs on the bus clock E. A free-running prescaler feeds a stage counter, and a 2-bit rate code picks how many prescaler periods may pass before the block asks for a reset. Software keeps the watchdog quiet with a two-step service sequence on an 8-bit service register. It first writes the arm key 0x55 and later writes the clear key 0xAA. Only a clear key that follows an arm key restarts the count. Because clearing leaves the prescaler running, the real timeout is never shorter than the nominal value. It can be up to one prescaler period longer.

A second function watches E itself. It runs on a free-running reference clock. E toggles a flop, a two-flop synchronizer brings that toggle into the reference domain, and a counter measures how long no E edge has been seen. Software can enable this monitor through a control bit. A separate force bit can only be set, and it keeps the monitor on until reset. Each reset source produces a one-cycle request pulse and a cause flag that stays set until it is cleared.

Top module: `cop_watchdog`

## Requirements
- R1: With control bits [1:0] equal to rate code c, a timeout request follows the last restart after between 4^c·P+1 and (4^c+1)·P rising edges of E, where P = 2^PRE_W. The edge that applied the restart counts as edge 0.
- R2: A service write of 0x55 arms the mechanism. A later service write of 0xAA restarts the count and disarms it.
- R3: A service write of 0xAA while the mechanism is not armed, including right after a completed clear, leaves the count running.
- R4: A service write of any value other than 0x55 or 0xAA is ignored and leaves the armed state unchanged, so 0x55, 0x12, 0xAA still restarts the count.
- R5: A timeout drives cop_rst_o high for exactly one E cycle and sets cop_flag_o. The flag holds until cop_flag_clr_i is sampled high.
- R6: While cop_dis_i is high, the count is held at zero and no timeout request is made. Counting resumes from zero when cop_dis_i is released.
- R7: With control bit 2 (monitor enable) and control bit 3 (force) both clear, a stopped E raises neither cm_fail_o nor cm_flag_o.
- R8: With the monitor on, an E that stays stopped for CM_LIMIT reference cycles gives exactly one cm_fail_o pulse and sets cm_flag_o. The flag holds until cm_flag_clr_i is sampled high on the reference clock.
- R9: Writing 1 to control bit 3 keeps the monitor on whatever bit 2 holds. Later writes of 0 do not clear it, and only reset does.
- R10: The clock monitor behaves the same whatever the level of cop_dis_i.
- R11: After reset all outputs are low, the mechanism is disarmed, the rate code is 00, and both monitor control bits are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| e_clk_i | input | 1 | Bus clock E |
| ref_clk_i | input | 1 | Free-running reference clock for the clock monitor |
| rst_ni | input | 1 | Asynchronous reset, active low, for both domains |
| wr_en_i | input | 1 | Register write strobe (E domain) |
| wr_sel_i | input | 1 | 0 selects the service register, 1 the control register |
| wr_data_i | input | 8 | Write data; control uses [1:0] rate, [2] monitor enable, [3] force |
| cop_dis_i | input | 1 | Global watchdog disable |
| cop_flag_clr_i | input | 1 | Clears the timeout cause flag (E domain) |
| cm_flag_clr_i | input | 1 | Clears the clock-failure cause flag (reference domain) |
| cop_rst_o | output | 1 | One-cycle timeout reset request |
| cop_flag_o | output | 1 | Timeout cause flag |
| cm_fail_o | output | 1 | One-cycle clock-failure reset request (reference domain) |
| cm_flag_o | output | 1 | Clock-failure cause flag |

## Verification
The bench builds the block with PRE_W = 4, so one prescaler period is 16 E cycles and even the slowest rate times out within about 1040 cycles. This lets every rate window be measured edge by edge, at both of its bounds. CM_LIMIT is set to 8 reference cycles. E runs at 5 ns and the reference clock at 7 ns, a ratio that stops the synchronized toggle from aliasing, so a failure appears within tens of nanoseconds after the bench gates E off.

// File: rtl/cop_wdg_pkg.sv
`timescale 1ns/1ps
package cop_wdg_pkg;

  typedef enum logic {
    WSEL_SERVICE = 1'b0,
    WSEL_CONTROL = 1'b1
  } wsel_e;

  localparam logic [7:0] KEY_ARM   = 8'h55;
  localparam logic [7:0] KEY_CLEAR = 8'hAA;

  localparam int unsigned RATE_W      = 2;
  localparam int unsigned MAX_SHIFT   = 2 * ((1 << RATE_W) - 1);
  localparam int unsigned TICK_W      = MAX_SHIFT + 1;

  typedef struct packed {
    logic              force_mon;
    logic              mon_en;
    logic [RATE_W-1:0] rate;
  } ctl_t;

  // prescaler periods allowed by a rate code: 4^code
  function automatic logic [TICK_W-1:0] ticks_for_rate(input logic [RATE_W-1:0] code);
    ticks_for_rate = TICK_W'(1) << {code, 1'b0};
  endfunction

endpackage

// File: rtl/cop_prescaler.sv
`timescale 1ns/1ps
module cop_prescaler #(
  parameter int unsigned PRE_W = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + PRE_W'(1);
  end

  assign tick_o = &cnt_q;

  AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R1

endmodule

// File: rtl/cop_key_seq.sv
`timescale 1ns/1ps
module cop_key_seq
  import cop_wdg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic       svc_clear_o,
  output logic       armed_o
);

  logic svc_wr;
  logic key_arm;
  logic key_clear;
  logic armed_q;

  assign svc_wr    = wr_en_i && (wr_sel_i == WSEL_SERVICE);
  assign key_arm   = svc_wr && (wr_data_i == KEY_ARM);
  assign key_clear = svc_wr && (wr_data_i == KEY_CLEAR);

  assign svc_clear_o = key_clear && armed_q;
  assign armed_o     = armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          armed_q <= 1'b0;
    else if (svc_clear_o) armed_q <= 1'b0;
    else if (key_arm)     armed_q <= 1'b1;
  end

  AST_ARM_ON_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_arm |=> armed_o); // R2
  AST_DISARM_ON_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_clear_o |=> !armed_o); // R2
  AST_UNARMED_CLEAR_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_clear && !armed_o) |-> !svc_clear_o); // R3
  AST_JUNK_KEEPS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_wr && !key_arm && !key_clear) |=> $stable(armed_o)); // R4

endmodule

// File: rtl/cop_timeout.sv
`timescale 1ns/1ps
module cop_timeout
  import cop_wdg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              clear_i,
  input  logic              dis_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              flag_clr_i,
  output logic              timeout_o,
  output logic              flag_o
);

  logic [TICK_W-1:0] cnt_q;
  logic [TICK_W-1:0] limit;
  logic              expire;
  logic              pulse_q;
  logic              flag_q;

  assign limit  = ticks_for_rate(rate_i);
  // timeout on the tick after the stage count reached the limit: never early
  assign expire = tick_i && !dis_i && !clear_i && (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (dis_i || clear_i) cnt_q <= '0;
    else if (tick_i) begin
      if (cnt_q >= limit)     cnt_q <= '0;
      else                    cnt_q <= cnt_q + TICK_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      pulse_q <= expire;
      if (expire)          flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign timeout_o = pulse_q;
  assign flag_o    = flag_q;

  AST_COUNT_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TICK_W'(1 << MAX_SHIFT)); // R1
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o); // R5
  AST_FLAG_WITH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> flag_o); // R5
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_i && $past(dis_i)) |-> !timeout_o); // R6

endmodule

// File: rtl/cop_clk_monitor.sv
`timescale 1ns/1ps
module cop_clk_monitor #(
  parameter int unsigned LIMIT = 64
) (
  input  logic e_clk_i,
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic mon_req_i,
  input  logic flag_clr_i,
  output logic fail_o,
  output logic flag_o
);

  localparam int unsigned CM_W = $clog2(LIMIT + 1);

  logic            tgl_q;
  logic [2:0]      tsync_q;
  logic [1:0]      en_sync_q;
  logic            e_edge;
  logic            en_s;
  logic [CM_W-1:0] gap_q;
  logic            expire;
  logic            fail_q;
  logic            flag_q;

  always_ff @(posedge e_clk_i or negedge rst_ni) begin
    if (!rst_ni) tgl_q <= 1'b0;
    else         tgl_q <= ~tgl_q;
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tsync_q   <= '0;
      en_sync_q <= '0;
    end else begin
      tsync_q   <= {tsync_q[1:0], tgl_q};
      en_sync_q <= {en_sync_q[0], mon_req_i};
    end
  end

  assign e_edge = tsync_q[2] ^ tsync_q[1];
  assign en_s   = en_sync_q[1];
  assign expire = en_s && !e_edge && (gap_q == CM_W'(LIMIT - 1));

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni)                       gap_q <= '0;
    else if (!en_s || e_edge)          gap_q <= '0;
    else if (gap_q != CM_W'(LIMIT))    gap_q <= gap_q + CM_W'(1);
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      fail_q <= expire;
      if (expire)          flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign fail_o = fail_q;
  assign flag_o = flag_q;

  AST_NO_FAIL_WHEN_OFF: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !en_s |=> !fail_o); // R7
  AST_SINGLE_FAIL: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    fail_o |=> !fail_o); // R8
  AST_FAIL_SETS_FLAG: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    fail_o |-> flag_o); // R8
  AST_EDGE_CLEARS_GAP: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    e_edge |=> !fail_o); // R8

endmodule

// File: rtl/cop_watchdog.sv
`timescale 1ns/1ps
module cop_watchdog
  import cop_wdg_pkg::*;
#(
  parameter int unsigned PRE_W    = 15,
  parameter int unsigned CM_LIMIT = 64
) (
  input  logic       e_clk_i,
  input  logic       ref_clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       wr_sel_i,
  input  logic [7:0] wr_data_i,
  input  logic       cop_dis_i,
  input  logic       cop_flag_clr_i,
  input  logic       cm_flag_clr_i,
  output logic       cop_rst_o,
  output logic       cop_flag_o,
  output logic       cm_fail_o,
  output logic       cm_flag_o
);

  logic              ctl_wr;
  ctl_t              ctl_in;
  logic [RATE_W-1:0] rate_q;
  logic              mon_en_q;
  logic              force_q;
  logic              mon_req;
  logic              tick;
  logic              svc_clear;
  logic              armed;

  assign ctl_wr = wr_en_i && (wr_sel_i == WSEL_CONTROL);
  assign ctl_in = ctl_t'(wr_data_i[3:0]);

  always_ff @(posedge e_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q   <= '0;
      mon_en_q <= 1'b0;
      force_q  <= 1'b0;
    end else if (ctl_wr) begin
      rate_q   <= ctl_in.rate;
      mon_en_q <= ctl_in.mon_en;
      if (ctl_in.force_mon) force_q <= 1'b1;
    end
  end

  assign mon_req = mon_en_q | force_q;

  cop_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (e_clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  cop_key_seq u_keys (
    .clk_i       (e_clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .svc_clear_o (svc_clear),
    .armed_o     (armed)
  );

  cop_timeout u_tmo (
    .clk_i      (e_clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .clear_i    (svc_clear),
    .dis_i      (cop_dis_i),
    .rate_i     (rate_q),
    .flag_clr_i (cop_flag_clr_i),
    .timeout_o  (cop_rst_o),
    .flag_o     (cop_flag_o)
  );

  cop_clk_monitor #(.LIMIT(CM_LIMIT)) u_cm (
    .e_clk_i    (e_clk_i),
    .ref_clk_i  (ref_clk_i),
    .rst_ni     (rst_ni),
    .mon_req_i  (mon_req),
    .flag_clr_i (cm_flag_clr_i),
    .fail_o     (cm_fail_o),
    .flag_o     (cm_flag_o)
  );

  AST_FORCE_STICKY: assert property (@(posedge e_clk_i) disable iff (!rst_ni)
    force_q |=> force_q); // R9
  AST_FORCE_HOLDS_MON: assert property (@(posedge e_clk_i) disable iff (!rst_ni)
    (force_q && ctl_wr && !ctl_in.mon_en) |=> mon_req); // R9
  AST_CLEAR_ONLY_ARMED: assert property (@(posedge e_clk_i) disable iff (!rst_ni)
    svc_clear |-> armed); // R2

endmodule

// File: tb/cop_watchdog_bench.sv
`timescale 1ns/1ps
module cop_watchdog_bench;

  localparam int unsigned PRE_W = 4;
  localparam int          P     = 16;
  localparam int unsigned CM_LIMIT = 8;

  logic       e_clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       e_run = 1'b1;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       cop_dis = 1'b0;
  logic       cop_clr = 1'b0;
  logic       cm_clr = 1'b0;
  logic       cop_rst, cop_flag, cm_fail, cm_flag;

  int errors = 0;
  int checks = 0;
  int ecnt = 0;
  int last_edge = 0;
  int cop_pulses = 0;
  int cm_pulses = 0;

  always #2.5 if (e_run || e_clk) e_clk = ~e_clk;
  always #3.5 ref_clk = ~ref_clk;

  always @(posedge e_clk) ecnt++;
  always @(negedge e_clk) if (cop_rst) cop_pulses++;
  always @(negedge ref_clk) if (cm_fail) cm_pulses++;

  cop_watchdog #(.PRE_W(PRE_W), .CM_LIMIT(CM_LIMIT)) u_cop_watchdog (
    .e_clk_i        (e_clk),
    .ref_clk_i      (ref_clk),
    .rst_ni         (rst_n),
    .wr_en_i        (wr_en),
    .wr_sel_i       (wr_sel),
    .wr_data_i      (wr_data),
    .cop_dis_i      (cop_dis),
    .cop_flag_clr_i (cop_clr),
    .cm_flag_clr_i  (cm_clr),
    .cop_rst_o      (cop_rst),
    .cop_flag_o     (cop_flag),
    .cm_fail_o      (cm_fail),
    .cm_flag_o      (cm_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_win(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  function automatic int nominal_ticks(input int code);
    case (code)
      0: return 1;
      1: return 4;
      2: return 16;
      default: return 64;
    endcase
  endfunction

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge e_clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge e_clk);
    wr_en = 1'b0;
    last_edge = ecnt;
  endtask

  task automatic service();
    wr(1'b0, 8'h55);
    wr(1'b0, 8'hAA);
  endtask

  task automatic wait_pulse(input int ref_edge, input int limit, output int k);
    k = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge e_clk);
      if (cop_rst) begin
        k = ecnt - ref_edge;
        break;
      end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #20;
    @(negedge e_clk);
    rst_n = 1'b1;
    last_edge = ecnt;
  endtask

  task automatic t_reset_state();
    int k;
    do_reset();
    chk(cop_rst == 1'b0, "R11 cop_rst_o after reset", int'(cop_rst), 0);
    chk(cop_flag == 1'b0, "R11 cop_flag_o after reset", int'(cop_flag), 0);
    chk(cm_fail == 1'b0, "R11 cm_fail_o after reset", int'(cm_fail), 0);
    chk(cm_flag == 1'b0, "R11 cm_flag_o after reset", int'(cm_flag), 0);
    wait_pulse(last_edge, 200, k);
    chk_win("R11 default rate 00 timeout", k, P + 1, 2 * P);
  endtask

  task automatic t_rates();
    int k;
    for (int c = 0; c < 4; c++) begin
      wr(1'b1, 8'(c));
      service();
      wait_pulse(last_edge, 2000, k);
      chk_win($sformatf("R1 rate code %0d window", c), k,
              nominal_ticks(c) * P + 1, (nominal_ticks(c) + 1) * P);
    end
  endtask

  task automatic t_pulse_flag();
    int k;
    wr(1'b1, 8'h01);
    service();
    wait_pulse(last_edge, 200, k);
    chk(k > 0, "R5 timeout seen", k, 1);
    chk(cop_flag == 1'b1, "R5 flag set with pulse", int'(cop_flag), 1);
    @(negedge e_clk);
    chk(cop_rst == 1'b0, "R5 pulse one cycle wide", int'(cop_rst), 0);
    chk(cop_flag == 1'b1, "R5 flag held", int'(cop_flag), 1);
    cop_clr = 1'b1;
    @(negedge e_clk);
    cop_clr = 1'b0;
    chk(cop_flag == 1'b0, "R5 flag cleared", int'(cop_flag), 0);
  endtask

  task automatic t_restart();
    int k;
    wr(1'b1, 8'h01);
    service();
    repeat (40) @(negedge e_clk);
    service();
    wait_pulse(last_edge, 200, k);
    chk_win("R2 arm then clear restarts count", k, 4 * P + 1, 5 * P);
  endtask

  task automatic t_unarmed_clear();
    int k;
    int e0;
    service();
    e0 = last_edge;
    repeat (30) @(negedge e_clk);
    wr(1'b0, 8'hAA);
    wr(1'b0, 8'hAA);
    wait_pulse(e0, 200, k);
    chk_win("R3 clear key without arm ignored", k, 4 * P + 1, 5 * P);
  endtask

  task automatic t_junk_write();
    int k;
    service();
    repeat (30) @(negedge e_clk);
    wr(1'b0, 8'h55);
    wr(1'b0, 8'h12);
    wr(1'b0, 8'hAA);
    wait_pulse(last_edge, 200, k);
    chk_win("R4 55,12,AA still restarts", k, 4 * P + 1, 5 * P);
  endtask

  task automatic t_disable();
    int k;
    int p0;
    wr(1'b1, 8'h00);
    @(negedge e_clk);
    cop_dis = 1'b1;
    repeat (2) @(negedge e_clk);
    p0 = cop_pulses;
    repeat (200) @(negedge e_clk);
    chk(cop_pulses == p0, "R6 no timeout while disabled", cop_pulses - p0, 0);
    cop_dis = 1'b0;
    wait_pulse(ecnt, 200, k);
    chk_win("R6 count restarts from zero on release", k, P + 1, 2 * P);
  endtask

  task automatic stop_e_and_count(output int delta);
    int c0;
    c0 = cm_pulses;
    e_run = 1'b0;
    #250;
    delta = cm_pulses - c0;
    e_run = 1'b1;
    #60;
  endtask

  task automatic clear_cm_flag();
    @(negedge ref_clk);
    cm_clr = 1'b1;
    @(negedge ref_clk);
    cm_clr = 1'b0;
    @(negedge ref_clk);
  endtask

  task automatic t_monitor_off();
    int d;
    wr(1'b1, 8'h03);
    #40;
    stop_e_and_count(d);
    chk(d == 0, "R7 stopped E with monitor off", d, 0);
    chk(cm_flag == 1'b0, "R7 no clock flag", int'(cm_flag), 0);
  endtask

  task automatic t_monitor_on();
    int d;
    wr(1'b1, 8'h07);
    #40;
    stop_e_and_count(d);
    chk(d == 1, "R8 one failure pulse", d, 1);
    chk(cm_flag == 1'b1, "R8 clock flag held", int'(cm_flag), 1);
    clear_cm_flag();
    chk(cm_flag == 1'b0, "R8 clock flag cleared", int'(cm_flag), 0);
  endtask

  task automatic t_monitor_dis();
    int d;
    cop_dis = 1'b1;
    #40;
    stop_e_and_count(d);
    chk(d == 1, "R10 monitor works with watchdog disabled", d, 1);
    cop_dis = 1'b0;
    clear_cm_flag();
  endtask

  task automatic t_force();
    int d;
    wr(1'b1, 8'h08);
    wr(1'b1, 8'h00);
    #40;
    stop_e_and_count(d);
    chk(d == 1, "R9 forced monitor survives zero write", d, 1);
    clear_cm_flag();
    do_reset();
    #40;
    stop_e_and_count(d);
    chk(d == 0, "R9 reset releases force", d, 0);
    chk(cm_flag == 1'b0, "R9 no clock flag after reset", int'(cm_flag), 0);
  endtask

  initial begin
    t_reset_state();
    t_rates();
    t_pulse_flag();
    t_restart();
    t_unarmed_clear();
    t_junk_write();
    t_disable();
    t_monitor_off();
    t_monitor_on();
    t_monitor_dis();
    t_force();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #900000;
    errors++;
    checks++;
    $display("FAIL watchdog all-requirements actual=hung expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule